// File: doc/BRIEF.md
# Per-Channel Streaming Sample Serializer

This block turns a time-ordered stream of parallel pin samples into a stream of per-channel words for an uncompressed streaming capture path. A strobe marks each new sample of the pin vector, which is up to 32 bits wide. Every 16 strobes, each enabled channel has collected 16 consecutive samples of its own pin in a shift register. That full set is moved into an output buffer, and sampling continues at once.

The buffered words are sent on a 16-bit valid/ready stream. The stream gives one word per enabled channel, in ascending channel order, and then moves on to the next group of samples. Channels that are not enabled produce no word and take no slot. A start pulse latches the channel-enable mask, clears the shift registers and begins sampling.

If a new group completes before the previous group has drained, the new group is dropped. A sticky overflow flag is raised in that case and stays set until it is cleared.

Top module: `chan_word_packer`

## Requirements
- R1: After reset, out_valid and overflow are 0, and no word appears until the first start pulse.
- R2: In each output word, bit k holds the k-th sample of that group for that channel. Bit 0 is the earliest sample and bit 15 the latest.
- R3: Each completed group yields exactly one word per enabled channel, in ascending channel index order. out_chan carries the channel index of the word on out_word.
- R4: A channel whose enable bit was 0 at start produces no word.
- R5: en_mask is sampled only in the cycle where start is 1. Changes to en_mask at any other time have no effect until the next start.
- R6: With an all-zero latched mask, out_valid stays 0 and overflow stays 0, whatever the strobe activity.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_word and out_chan hold their values.
- R8: Sampling continues while words drain. With strobes on every cycle and out_ready held at 1, consecutive groups are delivered with no lost samples.
- R9: A group is dropped when it completes while words of the previous group remain, not counting a word accepted in that same cycle. The dropped group sets overflow. overflow stays 1 until ovf_clr or start is asserted. The words already buffered are still delivered.
- R10: A start pulse discards partly collected samples and any undelivered words, and restarts the 16-sample group count.
- R11: Strobes before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch en_mask, clear collection state, begin sampling |
| en_mask | input | NCH | Channel enable mask, bit c enables channel c |
| pins | input | NCH | Sampled pin vector |
| strobe | input | 1 | One sample of pins is taken in a cycle where this is 1 |
| ovf_clr | input | 1 | Clear the overflow flag |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is offered |
| out_word | output | SPW | 16 samples of one channel, oldest in bit 0 |
| out_chan | output | $clog2(NCH) | Channel index of out_word |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
The assertions check on every cycle that an offered word belongs to an enabled channel, that a stalled word holds still, and that channel indices rise within a group. They also check that a completion on a busy drain raises overflow and that the flag then stays set, and that an empty mask never offers a word. Only the bench scenarios can show the data content: the bit-to-time ordering of each word, the dropping of disabled channels from real sample patterns, and the continuity of samples across back-to-back groups. The same holds for the cycle-exact boundary where the last pop and a group completion meet without overflow.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

  // Shift-in of one sample at the top: after SPW shifts the oldest sits in bit 0.
  function automatic logic [15:0] shift_in16(logic [15:0] cur, logic din);
    return {din, cur[15:1]};
  endfunction
endpackage

// File: rtl/cwp_lane.sv
module cwp_lane #(
  parameter int SPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           shift,
  input  logic           din,
  input  logic           load,
  output logic [SPW-1:0] word_o
);
  logic [SPW-1:0] sh_q;
  logic [SPW-1:0] sh_nxt;

  assign sh_nxt = {din, sh_q[SPW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_o <= '0;
    end else if (clr) begin
      sh_q <= '0;
    end else if (shift) begin
      sh_q <= sh_nxt;
      if (load) word_o <= sh_nxt;
    end
  end
endmodule

// File: rtl/cwp_pick.sv
module cwp_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer #(
  parameter int NCH = 32,
  parameter int SPW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCH-1:0]         en_mask,
  input  logic [NCH-1:0]         pins,
  input  logic                   strobe,
  input  logic                   ovf_clr,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [SPW-1:0]         out_word,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic                   overflow
);
  import cwp_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(SPW);
  localparam logic [CW-1:0] LAST = CW'(SPW - 1);

  run_state_t     state_q;
  logic [NCH-1:0] mask_q;
  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] pend_q;

  // Named internal events, observed by the checker.
  logic           take;
  logic           grp_done;
  logic           pop;
  logic [NCH-1:0] pop_vec;
  logic           drain_busy;
  logic           grp_load;

  logic [SPW-1:0] lane_word [NCH];
  logic [CHW-1:0] cur;
  logic           any_pend;

  assign take       = (state_q == ST_RUN) && strobe && !start;
  assign grp_done   = take && (cnt_q == LAST);
  assign pop        = out_valid && out_ready;
  assign pop_vec    = pop ? (NCH'(1) << cur) : '0;
  assign drain_busy = |(pend_q & ~pop_vec);
  assign grp_load   = grp_done && !drain_busy;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_lane
      cwp_lane #(.SPW(SPW)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .shift (take),
        .din   (pins[c]),
        .load  (grp_load),
        .word_o(lane_word[c])
      );
    end
  endgenerate

  cwp_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req(pend_q),
    .idx(cur),
    .any(any_pend)
  );

  assign out_valid = any_pend;
  assign out_chan  = cur;
  assign out_word  = lane_word[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      overflow <= 1'b0;
    end else if (start) begin
      state_q  <= ST_RUN;
      mask_q   <= en_mask;
      cnt_q    <= '0;
      pend_q   <= '0;
      overflow <= 1'b0;
    end else begin
      if (take) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      if (grp_load) pend_q <= mask_q;
      else          pend_q <= pend_q & ~pop_vec;
      if (grp_done && drain_busy) overflow <= 1'b1;
      else if (ovf_clr)           overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
  parameter int NCH = 32,
  parameter int SPW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   ovf_clr,
  input logic                   out_ready,
  input logic                   out_valid,
  input logic [SPW-1:0]         out_word,
  input logic [$clog2(NCH)-1:0] out_chan,
  input logic                   overflow,
  input logic [NCH-1:0]         mask_q,
  input logic                   grp_done,
  input logic                   drain_busy,
  input logic                   grp_load
);
  p_chan_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mask_q[out_chan]);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_word) && $stable(out_chan)));

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !start && !grp_load) |=> (!out_valid || (out_chan > $past(out_chan))));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && drain_busy && !start) |=> overflow);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr && !start) |=> overflow);

  p_empty_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !out_valid);
endmodule

bind chan_word_packer cwp_checker #(.NCH(NCH), .SPW(SPW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ovf_clr   (ovf_clr),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_chan  (out_chan),
  .overflow  (overflow),
  .mask_q    (mask_q),
  .grp_done  (grp_done),
  .drain_busy(drain_busy),
  .grp_load  (grp_load)
);

// File: tb/sim_chan_word_packer.sv
module sim_chan_word_packer;
  localparam int NCH = 32;
  localparam int SPW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] en_mask = '0;
  logic [31:0] pins = '0;
  logic        strobe = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_word;
  logic [4:0]  out_chan;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  int cap_n = 0;
  logic [4:0]  cap_ch [64];
  logic [15:0] cap_w  [64];

  always #10 clk = ~clk;

  chan_word_packer #(.NCH(NCH), .SPW(SPW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .en_mask(en_mask), .pins(pins),
    .strobe(strobe), .ovf_clr(ovf_clr), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .out_chan(out_chan), .overflow(overflow)
  );

  // Record every accepted word; ready holds from negedge to the next posedge.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap_ch[cap_n] = out_chan;
      cap_w[cap_n]  = out_word;
      cap_n = cap_n + 1;
    end
  end

  // Stimulus: vector {mask, seed}
  localparam logic [63:0] VEC [5] = '{
    {32'hFFFF_FFFF, 32'h1234_5678},
    {32'h0000_0001, 32'hDEAD_BEEF},
    {32'h8000_0000, 32'h0F1E_2D3C},
    {32'hA5A5_0F0F, 32'h7777_0001},
    {32'h0001_8000, 32'hC001_D00D}
  };

  function automatic logic [31:0] pinval(logic [31:0] s, int k);
    return (s * 32'(k * 2 + 3)) ^ {s[15:0], s[31:16]} ^ (32'(k) * 32'h0101_0101);
  endfunction

  // Expected word: bit b is the (off+b)-th sample of channel c.
  function automatic logic [15:0] exp_word(logic [31:0] s, int off, int c);
    logic [15:0] w;
    for (int b = 0; b < 16; b++) begin
      logic [31:0] p;
      p = pinval(s, off + b);
      w[b] = p[c];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] m);
    @(negedge clk); start = 1'b1; en_mask = m;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic feed(input logic [31:0] s, input int off, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); pins = pinval(s, off + k); strobe = 1'b1;
    end
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compare captured words from index base against ngroups groups of mask m.
  task automatic expect_groups(input string req, input logic [31:0] m, input logic [31:0] s,
                               input int base, input int ngroups);
    int i = base;
    for (int g = 0; g < ngroups; g++) begin
      for (int c = 0; c < 32; c++) begin
        if (m[c]) begin
          check(cap_ch[i] == 5'(c), req, "channel order", 32'(cap_ch[i]), 32'(c));
          check(cap_w[i] == exp_word(s, g * 16, c), req, "word content",
                32'(cap_w[i]), 32'(exp_word(s, g * 16, c)));
          i++;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    check(overflow == 1'b0, "R1", "overflow after reset", 32'(overflow), 0);

    // R11 strobes before first start are ignored
    feed(32'h5555_AAAA, 0, 20);
    idle(4);
    check(cap_n == 0 && !out_valid, "R11", "words before start", 32'(cap_n), 0);

    // R2/R3/R4 vector table
    for (int v = 0; v < 5; v++) begin
      logic [31:0] m, s;
      m = VEC[v][63:32];
      s = VEC[v][31:0];
      cap_n = 0;
      do_start(m);
      feed(s, 0, 16);
      idle(40);
      check(cap_n == $countones(m), "R4", "word count per group", 32'(cap_n), 32'($countones(m)));
      expect_groups("R2", m, s, 0, 1);
    end

    // R5 mask changes after start have no effect
    cap_n = 0;
    do_start(32'h0000_0300);
    en_mask = 32'hFFFF_FFFF;
    feed(32'h2468_ACE1, 0, 16);
    idle(10);
    check(cap_n == 2, "R5", "words with late mask change", 32'(cap_n), 2);
    expect_groups("R5", 32'h0000_0300, 32'h2468_ACE1, 0, 1);

    // R6 empty mask
    cap_n = 0;
    do_start(32'h0);
    feed(32'hFFFF_FFFF, 0, 32);
    idle(4);
    check(cap_n == 0, "R6", "words with empty mask", 32'(cap_n), 0);
    check(overflow == 1'b0, "R6", "overflow with empty mask", 32'(overflow), 0);

    // R8 continuous strobes with draining in parallel
    cap_n = 0;
    do_start(32'h0000_0081);
    feed(32'h1357_9BDF, 0, 48);
    idle(6);
    check(cap_n == 6, "R8", "words over three groups", 32'(cap_n), 6);
    expect_groups("R8", 32'h0000_0081, 32'h1357_9BDF, 0, 3);
    check(overflow == 1'b0, "R8", "no overflow streaming", 32'(overflow), 0);

    // R7 stall holds, R9 overflow drops second group
    cap_n = 0;
    out_ready = 1'b0;
    do_start(32'h0000_0007);
    feed(32'h0BAD_F00D, 0, 16);
    idle(2);
    check(out_valid && out_chan == 0 && out_word == exp_word(32'h0BAD_F00D, 0, 0),
          "R7", "held word while stalled", 32'(out_word), 32'(exp_word(32'h0BAD_F00D, 0, 0)));
    feed(32'h0BAD_F00D, 16, 16);
    idle(1);
    check(overflow == 1'b1, "R9", "overflow set", 32'(overflow), 1);
    check(out_chan == 0 && out_word == exp_word(32'h0BAD_F00D, 0, 0), "R7",
          "word stable after stall", 32'(out_word), 32'(exp_word(32'h0BAD_F00D, 0, 0)));
    @(negedge clk); out_ready = 1'b1;
    idle(8);
    check(cap_n == 3, "R9", "only first group delivered", 32'(cap_n), 3);
    expect_groups("R9", 32'h0000_0007, 32'h0BAD_F00D, 0, 1);
    check(overflow == 1'b1, "R9", "overflow sticky", 32'(overflow), 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(overflow == 1'b0, "R9", "overflow cleared", 32'(overflow), 0);

    // R9 boundary: last pop in the same cycle as the next completion
    cap_n = 0;
    out_ready = 1'b0;
    do_start(32'h0000_0010);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); pins = pinval(32'h6B6B_1234, k); strobe = 1'b1;
      if (k == 31) out_ready = 1'b1;
    end
    @(negedge clk); strobe = 1'b0;
    idle(3);
    check(overflow == 1'b0, "R9", "no overflow at pop boundary", 32'(overflow), 0);
    check(cap_n == 2, "R9", "both groups at boundary", 32'(cap_n), 2);
    expect_groups("R9", 32'h0000_0010, 32'h6B6B_1234, 0, 2);

    // R10 restart discards partial samples
    cap_n = 0;
    do_start(32'h0000_C000);
    feed(32'hFEED_0000, 0, 5);
    do_start(32'h0000_C000);
    feed(32'h4321_8765, 0, 16);
    idle(6);
    check(cap_n == 2, "R10", "words after restart", 32'(cap_n), 2);
    expect_groups("R10", 32'h0000_C000, 32'h4321_8765, 0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule